// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block turns a bank of interrupt request lines into a vector of raw pending bits. Each source is configured on its own. It can be level-sensitive, where the pending bit follows the line or its inverse. It can be edge-sensitive, where a rising edge, a falling edge or either edge sets a pending bit that stays set until software removes it.

The lines are taken as already synchronous to the block clock and are sampled on every rising edge. The block remembers the level each line had at the previous sample, so that it can find edges. Software removes captured edges with a write-one-to-clear strobe and mask. That clear acts only on sources that are currently in edge mode. Masking, priority and output routing belong to the logic that consumes the pending vector.

The package supplies suggested power-on configuration vectors for a 51-source bank. Sense is 0x1F07FFF8FFFF, dual-edge is 0xF800070000 and polarity is 0x5F07FFF8FFFF.

Top module: `trig_detector`

## Requirements
- R1: Synchronous reset clears every pending bit and every remembered line level to 0, so a line that is high at the first sample after reset counts as a rising change.
- R2: A source whose sense bit is 1 is in level mode. One clock after a sample, its pending bit equals the sampled line when its polarity bit is 1, and the inverted line when its polarity bit is 0.
- R3: A source whose sense bit is 0 and whose dual-edge bit is 1 sets its pending bit whenever the sampled line differs from the remembered level.
- R4: An edge-mode source without dual-edge sets its pending bit on a 0-to-1 change when its polarity bit is 1, and on a 1-to-0 change when its polarity bit is 0. The opposite change has no effect.
- R5: In edge mode, the line returning to its idle level never clears a set pending bit.
- R6: When the clear strobe is 1, each edge-mode pending bit whose mask bit is 1 clears on that edge. When the strobe is 0, the mask has no effect. Level-mode pending bits never respond to the clear.
- R7: The remembered level of every source is updated with the sampled line on every clock, whatever the mode. A source moved from level mode to edge mode while its line is steady therefore sees no edge.
- R8: When an edge is detected on a source in the same cycle as a clear of that source, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | 51 | Synchronous interrupt request lines, one per source |
| sense_i | input | 51 | 1 = level mode, 0 = edge mode |
| polarity_i | input | 51 | Level mode: 1 = active high. Edge mode: 1 = rising, 0 = falling |
| both_edge_i | input | 51 | Edge mode: 1 = any change captures |
| clr_stb_i | input | 1 | Write-one-to-clear strobe for captured edges |
| clr_mask_i | input | 51 | Bits to clear while the strobe is 1 |
| raw_pend_o | output | 51 | Raw pending vector |

## Verification
Edge capture and the software clear can act on the same source in the same cycle. The bench provokes this with a directed step that drives a rising edge on every line while the strobe asserts an all-ones mask, and the result is judged by every pending bit staying set. During the random phase the strobe and mask are drawn on most cycles alongside random line changes, so collisions recur on many sources. A bench function, written from the requirements, rules that detection beats the clear, and each cycle's vector is compared against it.

// File: rtl/trig_det_pkg.sv
package trig_det_pkg;

    localparam int unsigned SRC_COUNT = 51;

    // Suggested power-on configuration for a 51-source bank
    localparam logic [SRC_COUNT-1:0] DFLT_SENSE    = 51'h1F07FFF8FFFF;
    localparam logic [SRC_COUNT-1:0] DFLT_BOTHEDGE = 51'h00F800070000;
    localparam logic [SRC_COUNT-1:0] DFLT_POLARITY = 51'h5F07FFF8FFFF;

    typedef enum logic [1:0] {
        TRIG_LEVEL     = 2'd0,
        TRIG_EDGE_ONE  = 2'd1,
        TRIG_EDGE_BOTH = 2'd2
    } trig_kind_e;

    typedef struct packed {
        logic sense;    // 1 = level
        logic pol;      // level: active high / edge: rising
        logic both;     // edge: any change
    } src_cfg_t;

    function automatic trig_kind_e kind_of(src_cfg_t c);
        if (c.sense)     return TRIG_LEVEL;
        else if (c.both) return TRIG_EDGE_BOTH;
        else             return TRIG_EDGE_ONE;
    endfunction

    // Active value of a level-mode source
    function automatic logic level_value(src_cfg_t c, logic cur);
        return cur ~^ c.pol;
    endfunction

    // Edge hit for a source given previous and current sample
    function automatic logic edge_hit(src_cfg_t c, logic prev, logic cur);
        logic h;
        unique case (kind_of(c))
            TRIG_EDGE_BOTH: h = cur ^ prev;
            TRIG_EDGE_ONE:  h = c.pol ? (cur & ~prev) : (~cur & prev);
            default:        h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/trig_prev_reg.sv
module trig_prev_reg #(
    parameter int unsigned N = trig_det_pkg::SRC_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] prev_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= line_i;
    end

    assign prev_o = prev_q;

    // R7
    prev_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (prev_o == $past(line_i)));

endmodule

// File: rtl/trig_src_eval.sv
module trig_src_eval
    import trig_det_pkg::*;
#(
    parameter int unsigned N = SRC_COUNT
) (
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] sense_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] both_i,
    output logic [N-1:0] hit_o,
    output logic [N-1:0] lvl_o
);

    for (genvar g = 0; g < N; g++) begin : g_src
        src_cfg_t cfg;
        assign cfg.sense = sense_i[g];
        assign cfg.pol   = pol_i[g];
        assign cfg.both  = both_i[g];
        assign hit_o[g]  = edge_hit(cfg, prev_i[g], line_i[g]);
        assign lvl_o[g]  = level_value(cfg, line_i[g]);
    end

endmodule

// File: rtl/trig_raw_store.sv
module trig_raw_store #(
    parameter int unsigned N = trig_det_pkg::SRC_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sense_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] hit_i,
    input  logic         clr_stb_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] raw_o
);

    logic [N-1:0] raw_q;
    logic [N-1:0] clr_eff;
    logic [N-1:0] edge_keep;
    logic [N-1:0] raw_d;

    assign clr_eff   = clr_stb_i ? clr_mask_i : '0;
    assign edge_keep = (raw_q & ~clr_eff) | hit_i;
    assign raw_d     = (sense_i & lvl_i) | (~sense_i & edge_keep);

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= raw_d;
    end

    assign raw_o = raw_q;

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((raw_q ^ $past(lvl_i)) & $past(sense_i)) == '0));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(raw_q) & ~$past(sense_i) & ~$past(clr_eff) & ~raw_q) == '0));

    // R6
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & ~$past(sense_i) & $past(clr_eff) & ~$past(hit_i)) == '0));

    // R8
    hit_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(hit_i) & ~raw_q) == '0));

endmodule

// File: rtl/trig_detector.sv
module trig_detector
    import trig_det_pkg::*;
#(
    parameter int unsigned N = SRC_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_line_i,
    input  logic [N-1:0] sense_i,
    input  logic [N-1:0] polarity_i,
    input  logic [N-1:0] both_edge_i,
    input  logic         clr_stb_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] raw_pend_o
);

    logic [N-1:0] prev_w;
    logic [N-1:0] hit_w;
    logic [N-1:0] lvl_w;

    trig_prev_reg #(.N(N)) u_prev (
        .clk    (clk),
        .rst    (rst),
        .line_i (irq_line_i),
        .prev_o (prev_w)
    );

    trig_src_eval #(.N(N)) u_eval (
        .line_i  (irq_line_i),
        .prev_i  (prev_w),
        .sense_i (sense_i),
        .pol_i   (polarity_i),
        .both_i  (both_edge_i),
        .hit_o   (hit_w),
        .lvl_o   (lvl_w)
    );

    trig_raw_store #(.N(N)) u_raw (
        .clk        (clk),
        .rst        (rst),
        .sense_i    (sense_i),
        .lvl_i      (lvl_w),
        .hit_i      (hit_w),
        .clr_stb_i  (clr_stb_i),
        .clr_mask_i (clr_mask_i),
        .raw_o      (raw_pend_o)
    );

endmodule

// File: tb/trig_detector_bench.sv
`timescale 1ns/1ps
module trig_detector_bench;
    import trig_det_pkg::*;

    localparam int unsigned N = SRC_COUNT;
    localparam logic [N-1:0] ONES = '1;
    localparam logic [N-1:0] ZERO = '0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] line = '0, sense = '0, pol = '0, both = '0, mask = '0;
    logic         stb = 1'b0;
    logic [N-1:0] raw;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [N-1:0] exp_raw = '0;
    logic [N-1:0] exp_prev = '0;

    always #10 clk = ~clk;

    trig_detector u_trig_detector (
        .clk        (clk),
        .rst        (rst),
        .irq_line_i (line),
        .sense_i    (sense),
        .polarity_i (pol),
        .both_edge_i(both),
        .clr_stb_i  (stb),
        .clr_mask_i (mask),
        .raw_pend_o (raw)
    );

    function automatic logic [N-1:0] model_next(
        logic [N-1:0] r, logic [N-1:0] p, logic [N-1:0] l,
        logic [N-1:0] s, logic [N-1:0] po, logic [N-1:0] b,
        logic st, logic [N-1:0] m);
        logic [N-1:0] o;
        for (int i = 0; i < N; i++) begin
            if (s[i]) o[i] = po[i] ? l[i] : !l[i];
            else begin
                logic e;
                if (b[i]) e = (l[i] != p[i]);
                else if (po[i]) e = l[i] && !p[i];
                else e = !l[i] && p[i];
                o[i] = e ? 1'b1 : ((st && m[i]) ? 1'b0 : r[i]);
            end
        end
        return o;
    endfunction

    task automatic step();
        @(posedge clk);
        if (rst) begin
            exp_raw  = '0;
            exp_prev = '0;
        end else begin
            exp_raw  = model_next(exp_raw, exp_prev, line, sense, pol, both, stb, mask);
            exp_prev = line;
        end
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [N-1:0] expv);
        total++;
        if (raw !== expv) begin
            bad++;
            $display("FAIL %s: raw=%h expected=%h", tag, raw, expv);
        end
    endtask

    task automatic drive(logic [N-1:0] l, logic s, logic [N-1:0] m);
        line = l; stb = s; mask = m;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] pat;
        int unsigned seed_set;
        seed_set = $urandom(32'd2024);
        @(negedge clk);
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        check("R1 reset clears pending", ZERO);

        // rising mode everywhere; previous level reset to 0
        sense = ZERO; both = ZERO; pol = ONES;
        drive(ONES, 1'b0, ZERO); step();
        check("R1 zero remembered level gives rise", ONES);

        drive(ONES, 1'b1, ONES); step();
        check("R6 clear with steady line", ZERO);

        drive(ZERO, 1'b0, ZERO); step();
        check("R4 falling change ignored in rising mode", ZERO);

        pol = ZERO;
        drive(ONES, 1'b0, ZERO); step();
        check("R4 rising change ignored in falling mode", ZERO);
        drive(ZERO, 1'b0, ZERO); step();
        check("R4 falling capture", ONES);

        drive(ONES, 1'b0, ZERO); step();
        check("R5 sticky after line returns", ONES);

        drive(ONES, 1'b0, ONES); step();
        check("R6 mask ignored without strobe", ONES);

        pat = ZERO; pat[5] = 1'b1;
        drive(ONES, 1'b1, pat); step();
        check("R6 selective clear", ONES & ~pat);

        both = ONES;
        drive(ONES, 1'b1, ONES); step();
        check("R6 full clear before dual-edge", ZERO);
        drive(ZERO, 1'b0, ZERO); step();
        check("R3 dual edge falling", ONES);
        drive(ZERO, 1'b1, ONES); step();
        drive(ONES, 1'b0, ZERO); step();
        check("R3 dual edge rising", ONES);

        // level mode
        sense = ONES; both = ZERO; pol = ONES;
        pat = {$urandom, $urandom};
        drive(pat, 1'b0, ZERO); step();
        check("R2 active-high level", pat);
        pol = ZERO;
        drive(pat, 1'b0, ZERO); step();
        check("R2 active-low level", ~pat);
        drive(pat, 1'b1, ONES); step();
        check("R6 level bits immune to clear", ~pat);

        // R7: level with line high, then switch to rising edge mode
        pol = ONES;
        drive(ONES, 1'b0, ZERO); step();
        sense = ZERO;
        drive(ONES, 1'b1, ONES); step();
        check("R7 remembered level tracked in level mode", ZERO);

        // R8: edge and clear together
        drive(ZERO, 1'b1, ONES); step();
        drive(ONES, 1'b1, ONES); step();
        check("R8 detection beats clear", ONES);

        // random phase against the model, starting from the defaults
        sense = DFLT_SENSE; both = DFLT_BOTHEDGE; pol = DFLT_POLARITY;
        exp_raw = raw;
        for (int c = 0; c < 3000; c++) begin
            if (c % 97 == 96) begin
                sense = {$urandom, $urandom};
                both  = {$urandom, $urandom};
                pol   = {$urandom, $urandom};
            end
            drive(line ^ ({$urandom, $urandom} & {$urandom, $urandom}),
                  ($urandom % 3) != 0, {$urandom, $urandom});
            step();
            check("R2 R3 R4 R5 R6 R8 random", exp_raw);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule